// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block produces the strobe timing for programmed-I/O register and data cycles on an ATA host controller with two channels of two drives each. Every drive owns a setup code and a packed active/recovery byte, loaded through a byte-wide write port. When a cycle is requested for a channel and drive, the block holds the address phase for the setup count, asserts the read or write strobe for the active count, then waits out the recovery count before pulsing done.

The counts are stored in a compact, non-linear encoding and decoded inside the block. On the secondary channel the two drives share one address-setup timing, so the longer of the two drives' setup values applies to cycles for either drive. Counts are captured when a cycle is accepted, so software may rewrite timing while a cycle is in flight without disturbing it.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset every setup code is 01 (2 clocks) and every active/recovery byte is 0x3F, so a cycle to any drive has 2 setup, 3 active and 1 recovery clock.
- R2: A cycle runs setup, then active, then recovery; cycleActive is high in all three phases, the read strobe (reqWrite=0) or the write strobe (reqWrite=1) is high only in the active phase, and the two strobes are never high together.
- R3: Setup code (data bits 7:6 of a setup write) decodes as 01 to 2 clocks, 10 to 3, 00 to 4 and 11 to 5.
- R4: The active count sits in bits 7:4 of the active/recovery byte; a value n from 1 to 15 gives n clocks and 0 gives 16 clocks.
- R5: The recovery count sits in bits 3:0; a value v from 1 to 14 gives v+1 clocks, 0 gives 16 clocks and 15 gives 1 clock.
- R6: A secondary-channel cycle for either drive uses the larger of the two decoded secondary setup counts.
- R7: Primary-channel drives use their own setup and active/recovery values independently.
- R8: Timing values are captured when a cycle is accepted; a register write during a cycle affects only later cycles.
- R9: done is high for exactly one clock, the first idle clock after recovery; a request is accepted only in idle, and requests made while busy are dropped.
- R10: Write address bit 2 selects the channel, bit 1 the drive, and bit 0 selects the setup code (0) or the active/recovery byte (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Timing register write enable |
| regAddr | input | 3 | Timing register address {channel, drive, byte select} |
| regData | input | 8 | Timing register write data |
| reqValid | input | 1 | Cycle request, sampled in idle |
| reqChan | input | 1 | Requested channel |
| reqDrive | input | 1 | Requested drive |
| reqWrite | input | 1 | 1 for a write cycle, 0 for a read cycle |
| cycleActive | output | 1 | High while address is held (setup, active, recovery) |
| selChan | output | 1 | Channel of the cycle in progress |
| selDrive | output | 1 | Drive of the cycle in progress |
| readStrobe | output | 1 | Read strobe, active high |
| writeStrobe | output | 1 | Write strobe, active high |
| done | output | 1 | One-clock pulse when a cycle completes |

## Verification
A wrong decode or a wrong latched count shows as a strobe width or a setup or recovery gap that differs from the programmed value, visible within the first cycle issued after the change, so each encoding corner is measured by issuing a cycle and counting clocks per phase. A phase-sequencing fault shows as a missing or doubled done pulse, a strobe outside the address window, or a second cycle starting from a request that arrived while busy. Mid-cycle writes are checked across two consecutive cycles so that a count taken live instead of captured shows in the first.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_RECOVER
  } phase_t;

  typedef struct packed {
    logic capture;
    logic loadActive;
    logic loadRecover;
    logic countDown;
  } ctlStrobes_t;

  function automatic logic [CNT_W-1:0] decodeSetup(input logic [1:0] code);
    case (code)
      2'b01:   return CNT_W'(2);
      2'b10:   return CNT_W'(3);
      2'b00:   return CNT_W'(4);
      default: return CNT_W'(5);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] decodeActive(input logic [3:0] nib);
    return (nib == 4'd0) ? CNT_W'(16) : CNT_W'(nib);
  endfunction

  function automatic logic [CNT_W-1:0] decodeRecover(input logic [3:0] nib);
    if (nib == 4'd0) return CNT_W'(16);
    if (nib == 4'd15) return CNT_W'(1);
    return CNT_W'(nib) + CNT_W'(1);
  endfunction

endpackage

// File: rtl/pio_timing_datapath.sv
module pio_timing_datapath
  import pio_timing_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regData,
  input  logic              reqChan,
  input  logic              reqDrive,
  input  logic              reqWrite,
  input  ctlStrobes_t       ctl,
  output logic              cntZero,
  output logic              latChan,
  output logic              latDrive,
  output logic              latWrite
);

  localparam int N_SLOT = 4;
  localparam int IDX_W  = $clog2(N_SLOT);

  logic [1:0]        setupCode [N_SLOT];
  logic [DATA_W-1:0] arByte    [N_SLOT];
  logic [CNT_W-1:0]  setupDec  [N_SLOT];
  logic [CNT_W-1:0]  effSetup;
  logic [CNT_W-1:0]  activeLat;
  logic [CNT_W-1:0]  recoverLat;
  logic [CNT_W-1:0]  counter;
  logic [IDX_W-1:0]  wrIdx;
  logic [IDX_W-1:0]  rqIdx;

  assign wrIdx = regAddr[ADDR_W-1:1];
  assign rqIdx = {reqChan, reqDrive};

  // Register file: per-slot setup code and active/recovery byte
  generate
    for (genvar s = 0; s < N_SLOT; s++) begin : gSlot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          setupCode[s] <= 2'b01;
          arByte[s]    <= 8'h3F;
        end else if (regWe && wrIdx == IDX_W'(s)) begin
          if (regAddr[0]) arByte[s] <= regData;
          else            setupCode[s] <= regData[DATA_W-1:DATA_W-2];
        end
      end
      assign setupDec[s] = decodeSetup(setupCode[s]);
    end
  endgenerate

  // Secondary channel: slower of the two drives' setup applies
  always_comb begin
    if (reqChan)
      effSetup = (setupDec[2] > setupDec[3]) ? setupDec[2] : setupDec[3];
    else
      effSetup = setupDec[rqIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      counter    <= '0;
      activeLat  <= CNT_W'(1);
      recoverLat <= CNT_W'(1);
      latChan    <= 1'b0;
      latDrive   <= 1'b0;
      latWrite   <= 1'b0;
    end else if (ctl.capture) begin
      counter    <= effSetup - CNT_W'(1);
      activeLat  <= decodeActive(arByte[rqIdx][7:4]);
      recoverLat <= decodeRecover(arByte[rqIdx][3:0]);
      latChan    <= reqChan;
      latDrive   <= reqDrive;
      latWrite   <= reqWrite;
    end else if (ctl.loadActive) begin
      counter <= activeLat - CNT_W'(1);
    end else if (ctl.loadRecover) begin
      counter <= recoverLat - CNT_W'(1);
    end else if (ctl.countDown) begin
      counter <= counter - CNT_W'(1);
    end
  end

  assign cntZero = (counter == '0);

  assert_active_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (activeLat >= CNT_W'(1)) && (activeLat <= CNT_W'(16)));

  assert_setup_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (effSetup >= CNT_W'(2)) && (effSetup <= CNT_W'(5)));

  assert_secondary_max_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqChan |-> (effSetup >= setupDec[2]) && (effSetup >= setupDec[3]));

  assert_one_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctl.capture, ctl.loadActive, ctl.loadRecover, ctl.countDown}) <= 1);

endmodule

// File: rtl/pio_timing_ctrl.sv
module pio_timing_ctrl
  import pio_timing_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        cntZero,
  output ctlStrobes_t ctl,
  output phase_t      phase,
  output logic        done
);

  phase_t nextPhase;

  always_comb begin
    ctl       = '0;
    nextPhase = phase;
    case (phase)
      PH_IDLE: if (reqValid) begin
        ctl.capture = 1'b1;
        nextPhase   = PH_SETUP;
      end
      PH_SETUP: if (cntZero) begin
        ctl.loadActive = 1'b1;
        nextPhase      = PH_ACTIVE;
      end else ctl.countDown = 1'b1;
      PH_ACTIVE: if (cntZero) begin
        ctl.loadRecover = 1'b1;
        nextPhase       = PH_RECOVER;
      end else ctl.countDown = 1'b1;
      PH_RECOVER: if (cntZero) nextPhase = PH_IDLE;
                  else ctl.countDown = 1'b1;
      default: nextPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= nextPhase;
      done  <= (phase == PH_RECOVER) && cntZero;
    end
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_recover_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (phase == PH_IDLE) && ($past(phase) == PH_RECOVER));

  assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ACTIVE) && (nextPhase != PH_ACTIVE) |=> (phase == PH_RECOVER));

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regData,
  input  logic       reqValid,
  input  logic       reqChan,
  input  logic       reqDrive,
  input  logic       reqWrite,
  output logic       cycleActive,
  output logic       selChan,
  output logic       selDrive,
  output logic       readStrobe,
  output logic       writeStrobe,
  output logic       done
);

  ctlStrobes_t ctl;
  phase_t      phase;
  logic        cntZero;
  logic        latWrite;

  pio_timing_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cntZero  (cntZero),
    .ctl      (ctl),
    .phase    (phase),
    .done     (done)
  );

  pio_timing_datapath #(.ADDR_W(3), .DATA_W(8)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regData  (regData),
    .reqChan  (reqChan),
    .reqDrive (reqDrive),
    .reqWrite (reqWrite),
    .ctl      (ctl),
    .cntZero  (cntZero),
    .latChan  (selChan),
    .latDrive (selDrive),
    .latWrite (latWrite)
  );

  assign cycleActive = (phase != PH_IDLE);
  assign readStrobe  = (phase == PH_ACTIVE) && !latWrite;
  assign writeStrobe = (phase == PH_ACTIVE) && latWrite;

  assert_strobe_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(readStrobe && writeStrobe));

  assert_busy_holds_sel_R9: assert property (@(posedge clk) disable iff (!rstN)
    cycleActive && $past(cycleActive) |-> $stable(selChan) && $stable(selDrive));

  assert_strobe_in_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe || writeStrobe) |-> cycleActive && !done);

endmodule

// File: tb/pio_cycle_timer_test.sv
module pio_cycle_timer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regData = '0;
  logic       reqValid = 1'b0;
  logic       reqChan = 1'b0;
  logic       reqDrive = 1'b0;
  logic       reqWrite = 1'b0;
  logic       cycleActive, selChan, selDrive, readStrobe, writeStrobe, done;

  int checks = 0;
  int errors = 0;
  int clkCount = 0;

  always #4 clk = ~clk;

  pio_cycle_timer uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] encSetup(input int n);
    if (n <= 2) return 2'b01;
    if (n == 3) return 2'b10;
    if (n == 4) return 2'b00;
    return 2'b11;
  endfunction

  function automatic logic [3:0] encRec(input int n);
    if (n <= 1) return 4'd15;
    if (n == 16) return 4'd0;
    return 4'(n - 1);
  endfunction

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic setSetup(input bit ch, input bit dr, input int n);
    writeReg({ch, dr, 1'b0}, {encSetup(n), 6'b0});
  endtask

  task automatic setAR(input bit ch, input bit dr, input int act, input int rec);
    writeReg({ch, dr, 1'b1}, {4'(act), encRec(rec)});
  endtask

  // Issue one cycle and count clocks in each phase (sampled at negedges)
  task automatic runCycle(input bit ch, input bit dr, input bit wr,
                          output int s, output int a, output int r,
                          output bit doneOk, output bit typeOk);
    int guard = 0;
    s = 0; a = 0; r = 0; typeOk = 1'b1;
    @(negedge clk);
    reqValid = 1'b1; reqChan = ch; reqDrive = dr; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    while (cycleActive && !readStrobe && !writeStrobe && guard < 100) begin
      s++; guard++; @(negedge clk);
    end
    while ((readStrobe || writeStrobe) && guard < 100) begin
      if (writeStrobe != wr || readStrobe == wr || selChan != ch || selDrive != dr)
        typeOk = 1'b0;
      a++; guard++; @(negedge clk);
    end
    while (cycleActive && !readStrobe && !writeStrobe && guard < 100) begin
      if (done) typeOk = 1'b0;
      r++; guard++; @(negedge clk);
    end
    doneOk = done && !cycleActive;
    @(negedge clk);
    if (done) doneOk = 1'b0;
  endtask

  task automatic expectCycle(input bit ch, input bit dr, input bit wr,
                             input int eS, input int eA, input int eR, input string req);
    int s, a, r;
    bit dOk, tOk;
    runCycle(ch, dr, wr, s, a, r, dOk, tOk);
    check(s == eS, req, "setup clocks", s, eS);
    check(a == eA, req, "strobe clocks", a, eA);
    check(r == eR, req, "recovery clocks", r, eR);
    check(dOk, "R9", "done single pulse after recovery", dOk, 1);
    check(tOk, "R2", "strobe type and selection", tOk, 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!cycleActive && !readStrobe && !writeStrobe && !done, "R1", "idle outputs after reset",
          {cycleActive, readStrobe, writeStrobe, done}, 0);
    for (int i = 0; i < 4; i++)
      expectCycle(i[1], i[0], i[0] ^ i[1], 2, 3, 1, "R1");
  endtask

  task automatic testSetupCodes();
    setAR(0, 0, 2, 2);
    for (int n = 2; n <= 5; n++) begin
      setSetup(0, 0, n);
      expectCycle(0, 0, n[0], n, 2, 2, "R3");
    end
    setSetup(0, 0, 0);
    expectCycle(0, 0, 1, 2, 2, 2, "R3");
  endtask

  task automatic testActive();
    int vals[5] = '{1, 2, 9, 15, 16};
    setSetup(0, 1, 2);
    foreach (vals[i]) begin
      setAR(0, 1, vals[i], 3);
      expectCycle(0, 1, 0, 2, vals[i], 3, "R4");
    end
  endtask

  task automatic testRecovery();
    int vals[6] = '{1, 2, 8, 14, 15, 16};
    foreach (vals[i]) begin
      setAR(0, 1, 4, vals[i]);
      expectCycle(0, 1, 1, 2, 4, vals[i], "R5");
    end
    writeReg(3'b011, 8'h4F);
    expectCycle(0, 1, 0, 2, 4, 1, "R5");
  endtask

  task automatic testSecondaryMax();
    setAR(1, 0, 3, 2);
    setAR(1, 1, 5, 4);
    setSetup(1, 0, 5);
    setSetup(1, 1, 2);
    expectCycle(1, 0, 0, 5, 3, 2, "R6");
    expectCycle(1, 1, 1, 5, 5, 4, "R6");
    setSetup(1, 0, 3);
    expectCycle(1, 1, 0, 3, 5, 4, "R6");
    setSetup(1, 1, 4);
    expectCycle(1, 0, 1, 4, 3, 2, "R6");
  endtask

  task automatic testPrimaryIndep();
    setSetup(0, 0, 5);
    setAR(0, 0, 6, 7);
    setSetup(0, 1, 3);
    setAR(0, 1, 2, 2);
    expectCycle(0, 0, 0, 5, 6, 7, "R7");
    expectCycle(0, 1, 1, 3, 2, 2, "R10");
  endtask

  task automatic testMidWrite();
    int s, a, r;
    bit dOk, tOk;
    setSetup(0, 0, 2);
    setAR(0, 0, 10, 3);
    fork
      runCycle(0, 0, 1, s, a, r, dOk, tOk);
      begin
        repeat (5) @(negedge clk);
        writeReg(3'b001, {4'd4, encRec(6)});
        writeReg(3'b000, {encSetup(5), 6'b0});
      end
    join
    check(s == 2, "R8", "in-flight setup unchanged", s, 2);
    check(a == 10, "R8", "in-flight strobe unchanged", a, 10);
    check(r == 3, "R8", "in-flight recovery unchanged", r, 3);
    expectCycle(0, 0, 1, 5, 4, 6, "R8");
  endtask

  task automatic testBusyIgnore();
    int s, a, r;
    bit dOk, tOk;
    setSetup(0, 0, 2);
    setAR(0, 0, 3, 2);
    fork
      runCycle(0, 0, 0, s, a, r, dOk, tOk);
      begin
        repeat (3) @(negedge clk);
        reqValid = 1'b1; reqChan = 1'b1; reqDrive = 1'b1; reqWrite = 1'b1;
        @(negedge clk);
        reqValid = 1'b0;
      end
    join
    check(tOk, "R9", "busy request did not change cycle", tOk, 1);
    check(a == 3 && s == 2 && r == 2, "R9", "original timing kept", a, 3);
    check(!cycleActive, "R9", "no cycle started from busy request", cycleActive, 0);
    @(negedge clk);
    check(!cycleActive && !done, "R9", "still idle", {cycleActive, done}, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      clkCount++;
      if (clkCount > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", clkCount, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSetupCodes();
    testActive();
    testRecovery();
    testSecondaryMax();
    testPrimaryIndep();
    testMidWrite();
    testBusyIgnore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule